// File: doc/BRIEF.md
# Three-Level Pulse Step Decoder

This block converts pulses on a single control line that can sit low, mid or high into single up or down steps of a 7-bit setting. The line reaches the block as two comparator flags, one raised while the line is below mid and one raised while it is above mid. Both flags are resynchronised to the system clock. A prescaler divides the system clock into a slow reference tick, and pulse widths are measured in whole ticks. A downward pulse raises the setting by one and an upward pulse lowers it by one. Each step is applied when the line settles back at mid. Counting is gated by an enable input.

Short pulses are discarded. The first qualifying pulse after reset is thrown away, because the comparators power up in an unknown state. A short holdoff after each step keeps two steps apart. The setting saturates at both ends instead of wrapping. While reset is held, the setting is loaded from a value supplied by a nonvolatile store.

Top module: `trilvl_step_decoder`

## Requirements
- R1: While `rst_n` is low, `setting` is loaded from `nv_value`, and it holds that value after reset is released until a step occurs.
- R2: A pulse from mid to low (`cmp_lo`=1, `cmp_hi`=0) lasting at least `ACCEPT_TICKS` reference ticks raises `setting` by exactly one.
- R3: A pulse from mid to high (`cmp_hi`=1, `cmp_lo`=0) lasting at least `ACCEPT_TICKS` ticks lowers `setting` by exactly one.
- R4: A pulse shorter than `ACCEPT_TICKS` ticks leaves `setting` unchanged. This covers both glitch-length pulses and widths between the reject and accept limits.
- R5: A pulse that ends while `cnt_en` is low leaves `setting` unchanged and does not use up the discard of R7.
- R6: A step is applied only once the line has returned to mid (both flags 0), and one pulse produces at most one step.
- R7: After reset, the first pulse that would otherwise step the setting is discarded.
- R8: At 127, a further increment leaves `setting` at 127.
- R9: At 0, a further decrement leaves `setting` at 0.
- R10: A pulse that begins less than `GAP_TICKS` ticks after a step is ignored.
- R11: A sample with both flags at 1 is ignored. It neither starts nor ends a pulse, and the line is taken to stay at its previous level.
- R12: A pulse that moves straight from low to high (or from high to low) without passing mid produces no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the setting from `nv_value` |
| cmp_lo | input | 1 | Asynchronous flag, 1 while the control line is below mid |
| cmp_hi | input | 1 | Asynchronous flag, 1 while the control line is above mid |
| cnt_en | input | 1 | Asynchronous count enable, 1 allows steps |
| nv_value | input | SET_W | Stored setting from the nonvolatile store, loaded during reset |
| setting | output | SET_W | Current saturating setting |

## Verification
The bench builds the block with `TICK_DIV`=4, `ACCEPT_TICKS`=20 and `GAP_TICKS`=10. With these values one pulse and its return to mid take only a few hundred clock cycles. That makes it practical to walk the setting into both saturation limits, starting from preload values of 125 and 1. The short tick also puts the holdoff window, the in-between rejected widths and the illegal both-flags glitch within a handful of ticks of one another. Each of those cases can therefore be placed on either side of its threshold with several ticks of margin for synchroniser and prescaler phase.

// File: rtl/trilvl_pkg.sv
// Shared types for the three-level step decoder.
package trilvl_pkg;
    // Decoded line level; MID is the idle state.
    typedef enum logic [1:0] {
        LVL_MID = 2'b00,
        LVL_LO  = 2'b01,
        LVL_HI  = 2'b10
    } level_t;
endpackage

// File: rtl/trilvl_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous flags.
// Assumes each bit is a slow level signal; no bus coherence is implied.
module trilvl_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_sync <= '0;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/trilvl_tick_gen.sv
// Reference tick generator: one-cycle strobe every DIV system clocks.
// Assumes DIV >= 1; DIV of 1 gives a tick on every cycle.
module trilvl_tick_gen #(
    parameter int DIV = 125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV == 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            // Free-running divider count that wraps at DIV-1.
            always_ff @(posedge clk) begin
                if (!rst_n)            cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/trilvl_pulse_qual.sv
// Pulse qualifier. Decodes the synchronised flags into a line level,
// times each excursion from mid in reference ticks, and issues one step
// request when a wide enough pulse returns to mid. It handles the
// enable gate, the discard of the first pulse after reset and the
// post-step holdoff. Assumes the flags are already synchronous.
module trilvl_pulse_qual
    import trilvl_pkg::*;
#(
    parameter int ACCEPT_TICKS = 200,
    parameter int GAP_TICKS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lo_s,
    input  logic hi_s,
    input  logic en_s,
    output logic step_req,
    output logic step_up
);
    localparam int WW = $clog2(ACCEPT_TICKS + 1);
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [WW-1:0] W_ACCEPT = WW'(ACCEPT_TICKS);
    localparam logic [GW-1:0] G_LOAD   = GW'(GAP_TICKS);

    level_t          lvl_q, lvl_d;
    level_t          dir_q;
    logic            void_q;
    logic            armed_q;
    logic [WW-1:0]   width_q;
    logic [GW-1:0]   gap_q;

    // Level decode; an illegal both-flags sample keeps the last level.
    always_comb begin
        unique case ({hi_s, lo_s})
            2'b00:   lvl_d = LVL_MID;
            2'b01:   lvl_d = LVL_LO;
            2'b10:   lvl_d = LVL_HI;
            default: lvl_d = lvl_q;
        endcase
    end

    // Pulse tracking, width timing, holdoff and step issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= LVL_MID;
            dir_q    <= LVL_MID;
            void_q   <= 1'b0;
            armed_q  <= 1'b0;
            width_q  <= '0;
            gap_q    <= '0;
            step_req <= 1'b0;
            step_up  <= 1'b0;
        end else begin
            step_req <= 1'b0;
            if (tick && gap_q != '0) gap_q <= gap_q - 1'b1;
            if (lvl_d != lvl_q) begin
                if (lvl_q == LVL_MID) begin
                    dir_q   <= lvl_d;
                    width_q <= '0;
                    void_q  <= (gap_q != '0);
                end else if (lvl_d == LVL_MID) begin
                    if (!void_q && width_q >= W_ACCEPT && en_s) begin
                        if (!armed_q) begin
                            armed_q <= 1'b1;
                        end else begin
                            step_req <= 1'b1;
                            step_up  <= (dir_q == LVL_LO);
                            gap_q    <= G_LOAD;
                        end
                    end
                end else begin
                    void_q <= 1'b1;
                end
            end else if (lvl_q != LVL_MID && tick && width_q != W_ACCEPT) begin
                width_q <= width_q + 1'b1;
            end
            lvl_q <= lvl_d;
        end
    end

    p_commit_at_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (lvl_q == LVL_MID));
    p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> $past(en_s));
    p_first_discard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> $past(armed_q));
    p_holdoff_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (gap_q == G_LOAD));
endmodule

// File: rtl/trilvl_sat_counter.sv
// Saturating up/down setting register, preloaded from the stored value
// during reset. Assumes at most one step request per cycle.
module trilvl_sat_counter #(
    parameter int SET_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_req,
    input  logic             step_up,
    input  logic [SET_W-1:0] nv_value,
    output logic [SET_W-1:0] setting_q
);
    localparam logic [SET_W-1:0] MAXV = '1;

    // Preload in reset, then step with clamping at both limits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setting_q <= nv_value;
        end else if (step_req) begin
            if (step_up && setting_q != MAXV)     setting_q <= setting_q + 1'b1;
            else if (!step_up && setting_q != '0) setting_q <= setting_q - 1'b1;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && step_up && setting_q == MAXV) |=> (setting_q == MAXV));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !step_up && setting_q == '0) |=> (setting_q == '0));
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !step_req |=> $stable(setting_q));
    p_single_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && step_up && setting_q != MAXV) |=> (setting_q == $past(setting_q) + 1'b1));
    p_single_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_req && !step_up && setting_q != '0) |=> (setting_q == $past(setting_q) - 1'b1));
endmodule

// File: rtl/trilvl_step_decoder.sv
// Top of the three-level pulse step decoder. It synchronises the two
// comparator flags and the enable, derives the reference tick,
// qualifies pulses and drives the saturating setting. Assumes the
// flags are never both legitimately high.
module trilvl_step_decoder #(
    parameter int SET_W        = 7,
    parameter int TICK_DIV     = 125,
    parameter int ACCEPT_TICKS = 200,
    parameter int GAP_TICKS    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_lo,
    input  logic             cmp_hi,
    input  logic             cnt_en,
    input  logic [SET_W-1:0] nv_value,
    output logic [SET_W-1:0] setting
);
    logic [2:0] raw_flags, sync_flags;
    logic       tick, step_req, step_up;

    assign raw_flags = {cnt_en, cmp_hi, cmp_lo};

    trilvl_sync #(.WIDTH(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_flags), .q_sync(sync_flags)
    );

    trilvl_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    trilvl_pulse_qual #(.ACCEPT_TICKS(ACCEPT_TICKS), .GAP_TICKS(GAP_TICKS)) u_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .lo_s(sync_flags[0]), .hi_s(sync_flags[1]), .en_s(sync_flags[2]),
        .step_req(step_req), .step_up(step_up)
    );

    trilvl_sat_counter #(.SET_W(SET_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step_req(step_req), .step_up(step_up),
        .nv_value(nv_value), .setting_q(setting)
    );
endmodule

// File: tb/trilvl_step_decoder_tb.sv
module trilvl_step_decoder_tb;
    localparam int SET_W  = 7;
    localparam int DIV    = 4;
    localparam int ACCEPT = 20;
    localparam int GAP    = 10;
    localparam int MAXV   = 127;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp_lo = 1'b0, cmp_hi = 1'b0, cnt_en = 1'b1;
    logic [SET_W-1:0] nv_value = 7'd125;
    logic [SET_W-1:0] setting;

    int checks = 0;
    int errors = 0;
    int exp_val = 125;
    bit armed = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    trilvl_step_decoder #(.SET_W(SET_W), .TICK_DIV(DIV), .ACCEPT_TICKS(ACCEPT),
                          .GAP_TICKS(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
        .cnt_en(cnt_en), .nv_value(nv_value), .setting(setting)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: setting=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input logic lo, input logic hi, input int ticks);
        cmp_lo = lo;
        cmp_hi = hi;
        repeat (ticks * DIV) @(negedge clk);
    endtask

    task automatic push(input string tag);
        exp_q.push_back(exp_val);
        tag_q.push_back(tag);
    endtask

    // Bench model of a qualified pulse ending with enable high.
    task automatic model_step(input bit up);
        if (!cnt_en) return;
        if (!armed) begin
            armed = 1'b1;
        end else if (up) begin
            if (exp_val != MAXV) exp_val++;
        end else begin
            if (exp_val != 0) exp_val--;
        end
    endtask

    // One clean pulse, then back to mid with a long idle gap.
    task automatic pulse(input bit up, input int ticks, input string tag);
        hold(up, !up, ticks);
        cmp_lo = 1'b0;
        cmp_hi = 1'b0;
        if (ticks >= ACCEPT + 2) model_step(up);
        push(tag);
        hold(1'b0, 1'b0, 25);
    endtask

    // Scoreboard monitor: compares each expected item once the result has settled.
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            repeat (12) @(negedge clk);
            check(int'(setting), exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(int'(setting), 125, "R1 preload");

        pulse(1'b1, 30, "R7 first pulse discarded");
        pulse(1'b1, 30, "R2 increment");
        pulse(1'b1, 3,  "R4 glitch rejected");
        pulse(1'b1, 12, "R4 in-between width rejected");
        pulse(1'b0, 30, "R3 decrement");
        pulse(1'b1, 30, "R2 increment to 126");
        pulse(1'b1, 30, "R8 increment to max");
        pulse(1'b1, 30, "R8 hold at max");

        cnt_en = 1'b0;
        hold(1'b0, 1'b0, 5);
        pulse(1'b0, 30, "R5 disabled pulse ignored");
        cnt_en = 1'b1;
        hold(1'b0, 1'b0, 5);

        // R11: illegal glitch inside a high pulse keeps it one pulse.
        hold(1'b0, 1'b1, 15);
        hold(1'b1, 1'b1, 2);
        hold(1'b0, 1'b1, 15);
        cmp_hi = 1'b0;
        model_step(1'b0);
        push("R11 illegal sample inside pulse");
        hold(1'b0, 1'b0, 25);
        hold(1'b1, 1'b1, 30);
        cmp_lo = 1'b0; cmp_hi = 1'b0;
        push("R11 illegal sample from mid");
        hold(1'b0, 1'b0, 25);

        // R12: direct swap without mid.
        hold(1'b1, 1'b0, 30);
        hold(1'b0, 1'b1, 30);
        cmp_hi = 1'b0;
        push("R12 low-to-high swap voided");
        hold(1'b0, 1'b0, 25);

        // R10: pulse started inside the holdoff window.
        hold(1'b0, 1'b1, 30);
        cmp_hi = 1'b0;
        model_step(1'b0);
        push("R3 decrement before holdoff");
        hold(1'b0, 1'b0, 3);
        hold(1'b0, 1'b1, 30);
        cmp_hi = 1'b0;
        push("R10 pulse in holdoff ignored");
        hold(1'b0, 1'b0, 25);
        pulse(1'b0, 30, "R10 pulse after holdoff counts");

        // Second reset from a low stored value.
        wait (exp_q.size() == 0);
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        nv_value = 7'd1;
        cnt_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b0;
        exp_val = 1;
        repeat (3) @(negedge clk);
        check(int'(setting), 1, "R1 preload after second reset");

        pulse(1'b0, 30, "R5 disabled pulse keeps discard");
        cnt_en = 1'b1;
        hold(1'b0, 1'b0, 5);
        pulse(1'b0, 30, "R7 first enabled pulse discarded");
        pulse(1'b0, 30, "R3 decrement to zero");
        pulse(1'b0, 30, "R9 hold at zero");
        pulse(1'b1, 30, "R6 one pulse one step");

        wait (exp_q.size() == 0);
        repeat (20) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule